// File: doc/BRIEF.md
# Codec Command/Response Ring Transport

This block carries codec commands out of a command ring in memory and carries codec replies back into a response ring in memory. Software fills command slots and advances the command write pointer. The block then fetches each slot, offers the word on a command handshake, and waits for every reply that command owes before it fetches the next one. A command addressed to the all-codecs target owes one reply per codec. Any other command owes one reply. Each reply is stored as an entry that holds the reply word, the index of the codec that sent it, and a flag marking replies the codec sent on its own initiative.

A register-only immediate path lets early boot code send one command and read its reply without any memory. This path works only while the rings are disabled. The response ring reports overflow through a sticky status bit. An interrupt flag rises after a programmable number of ring writes.

Register map (3-bit offset): 0 control (bit 0 ring enable, bits 15:8 interrupt threshold), 1 command write pointer, 2 command read pointer (read-only), 3 response write pointer (read-only), 4 response read pointer, 5 status, 6 immediate command (write-only, reads as zero), 7 immediate reply (read-only).

Top module: `codec_ring_xport`

## Requirements
- R1: After reset, the command read pointer, the response write pointer and the whole status register read zero, cmd_valid is 0 and mem_wr_en is 0.
- R2: While the ring is enabled and the command read pointer differs from the command write pointer, the block reads the slot at the read pointer and advances the read pointer by one modulo 2^RING_AW. It presents the word on cmd_data with cmd_valid, and holds both stable until cmd_ready is 1. It fetches nothing while the two pointers are equal.
- R3: After a command is accepted, the next command is not presented until the replies it owes have arrived. Command bits 31:28 name the target codec, and the value 4'hF means all codecs, which owes CODEC_N replies. Any other target value owes 1 reply.
- R4: A solicited reply (rsp_unsol = 0) to a ring command is written at the response write pointer as the entry {flag, codec index, word}. The flag is the top bit, the codec index sits at bits 32 +: CID_W and the word at bits 31:0. The pointer then advances by one modulo 2^RING_AW.
- R5: An unsolicited reply (rsp_unsol = 1) is written with flag 1 whenever the ring is enabled, whether or not a command is outstanding. It is dropped while the ring is disabled.
- R6: A solicited reply that arrives while no command is outstanding is ignored.
- R7: The response ring is full when the write pointer plus one equals the response read pointer. A reply that arrives while the ring is full is dropped and sets status bit 1 (overrun). That bit stays set until a 1 is written to it. Writing resumes once the ring has room.
- R8: Status bit 0 (interrupt) is set when the number of ring writes since the last time it was set reaches control bits 15:8. A threshold of 0 disables counting. Writing 1 to the bit clears it.
- R9: Writing offset 6 while the ring is disabled and nothing is busy sets status bit 2 (busy) on the next cycle and sends the written word as a command. Each solicited reply to it lands in offset 7, with its codec index at status bits 8 +: CID_W, and sets status bit 3 (valid). Valid is cleared by writing a 1 to it. Busy clears after the last reply owed. Nothing is written to the ring.
- R10: A write to offset 6 is ignored while the ring is enabled or while the immediate path is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data, combinational from reg_addr |
| mem_rd_en | output | 1 | Command slot read request |
| mem_rd_addr | output | RING_AW | Command slot index |
| mem_rd_data | input | 32 | Command slot contents, one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Response entry write strobe |
| mem_wr_addr | output | RING_AW | Response entry index |
| mem_wr_data | output | 33+CID_W | Response entry {flag, codec index, word} |
| cmd_valid | output | 1 | Command offered to the codecs |
| cmd_ready | input | 1 | Codec link accepts the command |
| cmd_data | output | 32 | Command word |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_unsol | input | 1 | Reply was not requested by a command |
| rsp_codec | input | CID_W | Index of the replying codec |
| rsp_data | input | 32 | Reply word |

## Verification
The bench builds the block with RING_AW = 4 and CODEC_N = 3. A 16-slot ring lets a short run wrap both pointers, fill the response ring to its 15-entry limit, and push past that limit to reach the overrun bit. Three codecs make an all-codecs command owe a distinct count of three replies, so a wrong reply count shows up as an early command or a missing entry. Expected entries, pointer values and reply words are computed arithmetically from the command words the bench places in its memory model.

// File: rtl/cring_pkg.sv
// Shared definitions for the codec ring transport: engine states,
// register offsets and the command target field.
package cring_pkg;
    typedef enum logic [2:0] {
        CE_IDLE,
        CE_FETCH,
        CE_LOAD,
        CE_SEND,
        CE_WAIT
    } ce_state_e;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_CMD_WP  = 3'd1;
    localparam logic [2:0] RA_CMD_RP  = 3'd2;
    localparam logic [2:0] RA_RSP_WP  = 3'd3;
    localparam logic [2:0] RA_RSP_RP  = 3'd4;
    localparam logic [2:0] RA_STATUS  = 3'd5;
    localparam logic [2:0] RA_IMM_CMD = 3'd6;
    localparam logic [2:0] RA_IMM_RSP = 3'd7;

    localparam int         TGT_LSB = 28;
    localparam logic [3:0] TGT_ALL = 4'hF;
endpackage

// File: rtl/cring_cmd_engine.sv
// Command engine: fetches command slots from the ring (or takes the
// immediate command), offers them on the command handshake and waits
// for the replies each one owes before moving on.
// Assumes memory read data arrives one cycle after mem_rd_en.
module cring_cmd_engine
    import cring_pkg::*;
#(
    parameter int RING_AW = 8,
    parameter int CODEC_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ring_en,
    input  logic [RING_AW-1:0] cmd_wp,
    input  logic               imm_wr,
    input  logic [31:0]        imm_cmd,
    input  logic               sol_in,
    input  logic [31:0]        mem_rd_data,
    input  logic               cmd_ready,
    output logic               mem_rd_en,
    output logic [RING_AW-1:0] cmd_rp,
    output logic               cmd_valid,
    output logic [31:0]        cmd_data,
    output logic               awaiting,
    output logic               cur_imm,
    output logic               imm_busy
);
    localparam int            OW     = $clog2(CODEC_N + 1);
    localparam logic [OW-1:0] BC_CNT = OW'(CODEC_N);
    localparam logic [OW-1:0] ONE    = OW'(1);

    ce_state_e     state;
    logic [31:0]   cmd_q;
    logic [31:0]   imm_q;
    logic          imm_pend;
    logic [OW-1:0] outst;

    // Sequencer: fetch, offer, count owed replies, plus immediate intake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CE_IDLE;
            cmd_rp   <= '0;
            cmd_q    <= '0;
            imm_q    <= '0;
            imm_pend <= 1'b0;
            imm_busy <= 1'b0;
            cur_imm  <= 1'b0;
            outst    <= '0;
        end else begin
            if (imm_wr && !ring_en && !imm_busy) begin
                imm_busy <= 1'b1;
                imm_pend <= 1'b1;
                imm_q    <= imm_cmd;
            end
            case (state)
                CE_IDLE: begin
                    if (ring_en && (cmd_rp != cmd_wp)) begin
                        state <= CE_FETCH;
                    end else if (imm_pend) begin
                        cmd_q    <= imm_q;
                        cur_imm  <= 1'b1;
                        imm_pend <= 1'b0;
                        state    <= CE_SEND;
                    end
                end
                CE_FETCH: state <= CE_LOAD;
                CE_LOAD: begin
                    cmd_q   <= mem_rd_data;
                    cmd_rp  <= cmd_rp + 1'b1;
                    cur_imm <= 1'b0;
                    state   <= CE_SEND;
                end
                CE_SEND: begin
                    if (cmd_ready) begin
                        outst <= (cmd_q[TGT_LSB +: 4] == TGT_ALL) ? BC_CNT : ONE;
                        state <= CE_WAIT;
                    end
                end
                CE_WAIT: begin
                    if (sol_in) begin
                        outst <= outst - ONE;
                        if (outst == ONE) begin
                            state <= CE_IDLE;
                            if (cur_imm) begin
                                imm_busy <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= CE_IDLE;
            endcase
        end
    end

    // Handshake and status views of the sequencer state.
    always_comb begin
        mem_rd_en = (state == CE_FETCH);
        cmd_valid = (state == CE_SEND);
        cmd_data  = cmd_q;
        awaiting  = (state == CE_WAIT);
    end

    // R2: an offered command stays put until it is taken.
    p_hold_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    // R2: the read pointer only ever steps by one.
    p_rp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_rp) |-> cmd_rp == RING_AW'($past(cmd_rp) + 1'b1));

    // R9: busy drops only on a reply to the immediate command.
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(imm_busy) |-> $past(sol_in && cur_imm));
endmodule

// File: rtl/cring_rsp_engine.sv
// Response engine: routes each reply to the response ring or the
// immediate reply register, guards the ring against overflow and
// counts ring writes toward the interrupt flag.
// Assumes the memory write port accepts one entry every cycle.
module cring_rsp_engine #(
    parameter int RING_AW = 8,
    parameter int CID_W   = 2,
    parameter int ENT_W   = 33 + CID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ring_en,
    input  logic               rsp_valid,
    input  logic               rsp_unsol,
    input  logic [CID_W-1:0]   rsp_codec,
    input  logic [31:0]        rsp_data,
    input  logic               awaiting,
    input  logic               cur_imm,
    input  logic [RING_AW-1:0] rsp_rp,
    input  logic [7:0]         irq_thresh,
    input  logic               clr_irq,
    input  logic               clr_ovr,
    input  logic               clr_ival,
    output logic               mem_wr_en,
    output logic [ENT_W-1:0]   mem_wr_data,
    output logic [RING_AW-1:0] rsp_wp,
    output logic               irq,
    output logic               overrun,
    output logic               imm_valid,
    output logic [31:0]        imm_rsp,
    output logic [CID_W-1:0]   imm_codec
);
    logic       to_ring;
    logic       to_imm;
    logic       full;
    logic [7:0] wr_cnt;

    // Reply routing and ring-full detection.
    always_comb begin
        to_ring     = rsp_valid && ring_en && (rsp_unsol || (awaiting && !cur_imm));
        to_imm      = rsp_valid && !rsp_unsol && awaiting && cur_imm;
        full        = (RING_AW'(rsp_wp + 1'b1) == rsp_rp);
        mem_wr_en   = to_ring && !full;
        mem_wr_data = {rsp_unsol, rsp_codec, rsp_data};
    end

    // Ring write pointer and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_wp  <= '0;
            overrun <= 1'b0;
        end else begin
            if (mem_wr_en) begin
                rsp_wp <= rsp_wp + 1'b1;
            end
            if (to_ring && full) begin
                overrun <= 1'b1;
            end else if (clr_ovr) begin
                overrun <= 1'b0;
            end
        end
    end

    // Write counter that raises the interrupt flag at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            irq    <= 1'b0;
        end else begin
            if (irq_thresh == 8'd0) begin
                wr_cnt <= '0;
            end else if (mem_wr_en) begin
                if (({1'b0, wr_cnt} + 9'd1) >= {1'b0, irq_thresh}) begin
                    wr_cnt <= '0;
                end else begin
                    wr_cnt <= wr_cnt + 8'd1;
                end
            end
            if (mem_wr_en && (irq_thresh != 8'd0) &&
                (({1'b0, wr_cnt} + 9'd1) >= {1'b0, irq_thresh})) begin
                irq <= 1'b1;
            end else if (clr_irq) begin
                irq <= 1'b0;
            end
        end
    end

    // Immediate reply capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_valid <= 1'b0;
            imm_rsp   <= '0;
            imm_codec <= '0;
        end else if (to_imm) begin
            imm_valid <= 1'b1;
            imm_rsp   <= rsp_data;
            imm_codec <= rsp_codec;
        end else if (clr_ival) begin
            imm_valid <= 1'b0;
        end
    end

    // R4: the write pointer moves one step, and only after a write.
    p_wp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_wp) |-> $past(mem_wr_en) && rsp_wp == RING_AW'($past(rsp_wp) + 1'b1));

    // R7: overrun rises only when a ring-bound reply went unwritten.
    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rsp_valid && ring_en && !mem_wr_en));

    // R8: the interrupt flag rises only on a ring write.
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_wr_en));

    // R9: immediate valid rises only on a solicited reply to that path.
    p_imm_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(imm_valid) |-> $past(rsp_valid && !rsp_unsol && awaiting && cur_imm));
endmodule

// File: rtl/codec_ring_xport.sv
// Top of the codec command/response ring transport. Holds the software
// registers, decodes register writes into engine strobes and drives the
// register read mux. Assumes a single register master.
module codec_ring_xport
    import cring_pkg::*;
#(
    parameter int RING_AW = 8,
    parameter int CODEC_N = 4,
    parameter int CID_W   = $clog2(CODEC_N),
    parameter int ENT_W   = 33 + CID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wr_data,
    output logic [31:0]        reg_rd_data,
    output logic               mem_rd_en,
    output logic [RING_AW-1:0] mem_rd_addr,
    input  logic [31:0]        mem_rd_data,
    output logic               mem_wr_en,
    output logic [RING_AW-1:0] mem_wr_addr,
    output logic [ENT_W-1:0]   mem_wr_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [31:0]        cmd_data,
    input  logic               rsp_valid,
    input  logic               rsp_unsol,
    input  logic [CID_W-1:0]   rsp_codec,
    input  logic [31:0]        rsp_data
);
    logic               ring_en;
    logic [7:0]         irq_thresh;
    logic [RING_AW-1:0] cmd_wp;
    logic [RING_AW-1:0] cmd_rp;
    logic [RING_AW-1:0] rsp_wp;
    logic [RING_AW-1:0] rsp_rp;
    logic               imm_wr, clr_irq, clr_ovr, clr_ival;
    logic               awaiting, cur_imm, imm_busy;
    logic               irq, overrun, imm_valid;
    logic [31:0]        imm_rsp;
    logic [CID_W-1:0]   imm_codec;
    logic [31:0]        status;

    // Software-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_en    <= 1'b0;
            irq_thresh <= '0;
            cmd_wp     <= '0;
            rsp_rp     <= '0;
        end else if (reg_wr_en) begin
            case (reg_addr)
                RA_CTRL: begin
                    ring_en    <= reg_wr_data[0];
                    irq_thresh <= reg_wr_data[15:8];
                end
                RA_CMD_WP: cmd_wp <= reg_wr_data[RING_AW-1:0];
                RA_RSP_RP: rsp_rp <= reg_wr_data[RING_AW-1:0];
                default: ;
            endcase
        end
    end

    // Write strobes for the engines and status read view.
    always_comb begin
        imm_wr   = reg_wr_en && (reg_addr == RA_IMM_CMD);
        clr_irq  = reg_wr_en && (reg_addr == RA_STATUS) && reg_wr_data[0];
        clr_ovr  = reg_wr_en && (reg_addr == RA_STATUS) && reg_wr_data[1];
        clr_ival = reg_wr_en && (reg_addr == RA_STATUS) && reg_wr_data[3];
        status   = '0;
        status[0] = irq;
        status[1] = overrun;
        status[2] = imm_busy;
        status[3] = imm_valid;
        status[8 +: CID_W] = imm_codec;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rd_data = {16'd0, irq_thresh, 7'd0, ring_en};
            RA_CMD_WP:  reg_rd_data = 32'(cmd_wp);
            RA_CMD_RP:  reg_rd_data = 32'(cmd_rp);
            RA_RSP_WP:  reg_rd_data = 32'(rsp_wp);
            RA_RSP_RP:  reg_rd_data = 32'(rsp_rp);
            RA_STATUS:  reg_rd_data = status;
            RA_IMM_RSP: reg_rd_data = imm_rsp;
            default:    reg_rd_data = '0;
        endcase
    end

    assign mem_rd_addr = cmd_rp;
    assign mem_wr_addr = rsp_wp;

    cring_cmd_engine #(
        .RING_AW (RING_AW),
        .CODEC_N (CODEC_N)
    ) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_en     (ring_en),
        .cmd_wp      (cmd_wp),
        .imm_wr      (imm_wr),
        .imm_cmd     (reg_wr_data),
        .sol_in      (rsp_valid && !rsp_unsol),
        .mem_rd_data (mem_rd_data),
        .cmd_ready   (cmd_ready),
        .mem_rd_en   (mem_rd_en),
        .cmd_rp      (cmd_rp),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .awaiting    (awaiting),
        .cur_imm     (cur_imm),
        .imm_busy    (imm_busy)
    );

    cring_rsp_engine #(
        .RING_AW (RING_AW),
        .CID_W   (CID_W),
        .ENT_W   (ENT_W)
    ) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_en     (ring_en),
        .rsp_valid   (rsp_valid),
        .rsp_unsol   (rsp_unsol),
        .rsp_codec   (rsp_codec),
        .rsp_data    (rsp_data),
        .awaiting    (awaiting),
        .cur_imm     (cur_imm),
        .rsp_rp      (rsp_rp),
        .irq_thresh  (irq_thresh),
        .clr_irq     (clr_irq),
        .clr_ovr     (clr_ovr),
        .clr_ival    (clr_ival),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .rsp_wp      (rsp_wp),
        .irq         (irq),
        .overrun     (overrun),
        .imm_valid   (imm_valid),
        .imm_rsp     (imm_rsp),
        .imm_codec   (imm_codec)
    );
endmodule

// File: tb/codec_ring_xport_bench.sv
// Bench for codec_ring_xport: memory and codec models plus directed sweeps.
module codec_ring_xport_bench;
    localparam int CLK_P   = 10;
    localparam int RING_AW = 4;
    localparam int RING_N  = 1 << RING_AW;
    localparam int CODEC_N = 3;
    localparam int CID_W   = $clog2(CODEC_N);
    localparam int ENT_W   = 33 + CID_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr_en = 1'b0;
    logic [2:0]         reg_addr = 3'd0;
    logic [31:0]        reg_wr_data = '0;
    logic [31:0]        reg_rd_data;
    logic               mem_rd_en;
    logic [RING_AW-1:0] mem_rd_addr;
    logic [31:0]        mem_rd_data = '0;
    logic               mem_wr_en;
    logic [RING_AW-1:0] mem_wr_addr;
    logic [ENT_W-1:0]   mem_wr_data;
    logic               cmd_valid;
    logic               cmd_ready = 1'b1;
    logic [31:0]        cmd_data;
    logic               rsp_valid = 1'b0;
    logic               rsp_unsol = 1'b0;
    logic [CID_W-1:0]   rsp_codec = '0;
    logic [31:0]        rsp_data = '0;

    codec_ring_xport #(.RING_AW(RING_AW), .CODEC_N(CODEC_N)) u_codec_ring_xport (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_unsol(rsp_unsol), .rsp_codec(rsp_codec),
        .rsp_data(rsp_data)
    );

    always #(CLK_P / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0]      cmd_mem [RING_N];
    logic [ENT_W-1:0] rsp_mem [RING_N];

    // Memory model: one-cycle read, plain write.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= cmd_mem[mem_rd_addr];
        if (mem_wr_en) rsp_mem[mem_wr_addr] <= mem_wr_data;
    end

    function automatic logic [31:0] exp_resp(input logic [31:0] c, input int codec);
        return {4'(codec), c[27:0] + 28'd1};
    endfunction

    function automatic logic [ENT_W-1:0] ent(input bit u, input int codec, input logic [31:0] d);
        return {u, CID_W'(codec), d};
    endfunction

    // Codec model state: requests come from the initial block only.
    bit          auto_en = 1'b1;
    int          unsol_req = 0, stray_req = 0;
    int          unsol_srv = 0, stray_srv = 0;
    int          pend = 0, viol = 0, sent_n = 0, mc = 0;
    logic [31:0] sent_log [64];
    logic [31:0] cur_cmd = '0;
    bit          cur_bc = 1'b0;

    // Codec model: answer owed replies, then stray and unsolicited ones.
    always @(negedge clk) begin
        if (cmd_valid && pend > 0) viol++;
        rsp_valid = 1'b0;
        rsp_unsol = 1'b0;
        if (pend > 0) begin
            mc = cur_bc ? (CODEC_N - pend) : int'(cur_cmd[31:28]);
            rsp_valid = 1'b1;
            rsp_codec = CID_W'(mc);
            rsp_data  = exp_resp(cur_cmd, mc);
            pend--;
        end else if (stray_srv < stray_req) begin
            rsp_valid = 1'b1;
            rsp_codec = '0;
            rsp_data  = 32'h5700_0000 + 32'(stray_srv);
            stray_srv++;
        end else if (unsol_srv < unsol_req) begin
            rsp_valid = 1'b1;
            rsp_unsol = 1'b1;
            rsp_codec = CID_W'(unsol_srv % CODEC_N);
            rsp_data  = 32'hA000_0000 + 32'(unsol_srv);
            unsol_srv++;
        end
        if (cmd_valid && cmd_ready) begin
            sent_log[sent_n] = cmd_data;
            sent_n++;
            if (auto_en) begin
                cur_cmd = cmd_data;
                cur_bc  = (cmd_data[31:28] == 4'hF);
                pend    = cur_bc ? CODEC_N : 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic set_ctrl(input bit en, input int thr);
        reg_write(3'd0, {16'd0, 8'(thr), 7'd0, en});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [31:0] rd;
    int          e, s0;
    logic [31:0] c;

    initial begin
        for (int i = 0; i < RING_N; i++) cmd_mem[i] = '0;
        run(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        reg_read(3'd2, rd); chk("R1 cmd_rp", rd, 0);
        reg_read(3'd3, rd); chk("R1 rsp_wp", rd, 0);
        reg_read(3'd5, rd); chk("R1 status", rd, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 mem_wr_en", mem_wr_en, 0);

        // R2 R3 R4: six ring commands, two to all codecs
        for (int i = 0; i < 6; i++)
            cmd_mem[i] = {((i == 2 || i == 5) ? 4'hF : 4'(i % 3)), 8'(i), 20'h000C0 + 20'(i)};
        set_ctrl(1'b1, 0);
        reg_write(3'd1, 32'd6);
        run(120);
        reg_read(3'd2, rd); chk("R2 cmd_rp after 6", rd, 6);
        reg_read(3'd3, rd); chk("R3 rsp_wp owes 1 or CODEC_N", rd, 10);
        chk("R3 no command while replies owed", viol, 0);
        for (int i = 0; i < 6; i++) chk("R2 fetch order", sent_log[i], cmd_mem[i]);
        e = 0;
        for (int i = 0; i < 6; i++) begin
            if (cmd_mem[i][31:28] == 4'hF) begin
                for (int k = 0; k < CODEC_N; k++) begin
                    chk("R4 entry bcast", rsp_mem[e], ent(1'b0, k, exp_resp(cmd_mem[i], k)));
                    e++;
                end
            end else begin
                chk("R4 entry", rsp_mem[e], ent(1'b0, i % 3, exp_resp(cmd_mem[i], i % 3)));
                e++;
            end
        end

        // R2 R4: 14 more commands, both pointers wrap
        reg_write(3'd4, 32'd10);
        for (int j = 0; j < 14; j++)
            cmd_mem[(6 + j) % RING_N] = {4'(j % 3), 8'(j + 16), 20'h0B000 + 20'(j)};
        reg_write(3'd1, 32'd4);
        run(200);
        reg_read(3'd2, rd); chk("R2 cmd_rp wrapped", rd, 4);
        reg_read(3'd3, rd); chk("R4 rsp_wp wrapped", rd, 8);
        reg_read(3'd5, rd); chk("R7 no overrun below capacity", rd[1], 0);
        for (int j = 0; j < 14; j++) begin
            c = cmd_mem[(6 + j) % RING_N];
            chk("R2 wrap order", sent_log[6 + j], c);
            chk("R4 wrap entry", rsp_mem[(10 + j) % RING_N], ent(1'b0, j % 3, exp_resp(c, j % 3)));
        end

        // R5: unsolicited replies while idle
        reg_write(3'd4, 32'd8);
        unsol_req += 3; run(8);
        reg_read(3'd3, rd); chk("R5 rsp_wp after unsol", rd, 11);
        for (int k = 0; k < 3; k++)
            chk("R5 unsol entry", rsp_mem[8 + k], ent(1'b1, k % 3, 32'hA000_0000 + 32'(k)));

        // R6: stray solicited replies ignored
        stray_req += 2; run(6);
        reg_read(3'd3, rd); chk("R6 stray ignored", rd, 11);

        // R5: unsolicited dropped with ring disabled
        set_ctrl(1'b0, 0);
        unsol_req += 1; run(5);
        reg_read(3'd3, rd); chk("R5 drop when disabled", rd, 11);

        // R8: interrupt after threshold of 3
        set_ctrl(1'b1, 3);
        unsol_req += 2; run(6);
        reg_read(3'd5, rd); chk("R8 irq below threshold", rd[0], 0);
        unsol_req += 1; run(5);
        reg_read(3'd5, rd); chk("R8 irq at threshold", rd[0], 1);
        reg_write(3'd5, 32'h1);
        reg_read(3'd5, rd); chk("R8 irq cleared", rd[0], 0);

        // R7: overflow the ring
        set_ctrl(1'b1, 0);
        reg_write(3'd4, 32'd14);
        unsol_req += 17; run(25);
        reg_read(3'd3, rd); chk("R7 wp stops one short", rd, 13);
        reg_read(3'd5, rd); chk("R7 overrun set", rd[1], 1);
        run(3);
        reg_read(3'd5, rd); chk("R7 overrun sticky", rd[1], 1);
        reg_write(3'd5, 32'h2);
        reg_read(3'd5, rd); chk("R7 overrun cleared", rd[1], 0);
        reg_write(3'd4, 32'd13);
        unsol_req += 1; run(5);
        reg_read(3'd3, rd); chk("R7 resumes with room", rd, 14);
        chk("R7 resume entry", rsp_mem[13], ent(1'b1, 24 % 3, 32'hA000_0018));

        // R9: immediate command to codec 1
        set_ctrl(1'b0, 0);
        c = 32'h1070_0123;
        reg_write(3'd6, c);
        reg_read(3'd5, rd); chk("R9 busy set", rd[2], 1);
        run(20);
        reg_read(3'd5, rd); chk("R9 busy clear", rd[2], 0);
        chk("R9 valid", rd[3], 1);
        chk("R9 codec field", rd[8 +: CID_W], 1);
        reg_read(3'd7, rd); chk("R9 reply word", rd, exp_resp(c, 1));
        reg_read(3'd3, rd); chk("R9 ring untouched", rd, 14);
        reg_write(3'd5, 32'h8);
        reg_read(3'd5, rd); chk("R9 valid cleared", rd[3], 0);

        // R9: immediate command to all codecs keeps the last reply
        c = 32'hF0A0_0777;
        reg_write(3'd6, c);
        run(25);
        reg_read(3'd5, rd); chk("R9 bcast busy clear", rd[2], 0);
        chk("R9 bcast codec", rd[8 +: CID_W], CODEC_N - 1);
        reg_read(3'd7, rd); chk("R9 bcast last reply", rd, exp_resp(c, CODEC_N - 1));
        chk("R3 imm bcast no overlap", viol, 0);

        // R10: ignored while ring enabled
        set_ctrl(1'b1, 0);
        s0 = sent_n;
        reg_write(3'd6, 32'h0000_1111);
        run(10);
        reg_read(3'd5, rd); chk("R10 busy stays 0 when enabled", rd[2], 0);
        chk("R10 nothing sent when enabled", sent_n, s0);

        // R10: ignored while busy
        set_ctrl(1'b0, 0);
        auto_en = 1'b0;
        reg_write(3'd6, 32'h2000_0AAA);
        run(6);
        reg_write(3'd6, 32'h2000_0BBB);
        run(6);
        chk("R10 first sent once", sent_n, s0 + 1);
        chk("R10 first word", sent_log[s0], 32'h2000_0AAA);
        stray_req += 1; run(5);
        reg_read(3'd7, rd); chk("R9 stray answers imm", rd, 32'h5700_0002);
        reg_read(3'd5, rd); chk("R9 busy clear after reply", rd[2], 0);
        run(10);
        chk("R10 second never sent", sent_n, s0 + 1);
        auto_en = 1'b1;

        // R2: backpressure holds the offered command
        set_ctrl(1'b1, 0);
        cmd_ready = 1'b0;
        cmd_mem[4] = 32'h0055_0042;
        reg_write(3'd1, 32'd5);
        run(10);
        chk("R2 valid under stall", cmd_valid, 1);
        chk("R2 data under stall", cmd_data, 32'h0055_0042);
        run(3);
        chk("R2 data held", cmd_data, 32'h0055_0042);
        cmd_ready = 1'b1;
        run(20);
        reg_read(3'd2, rd); chk("R2 rp after stall", rd, 5);
        reg_read(3'd3, rd); chk("R4 wp after stall", rd, 15);
        chk("R4 stall entry", rsp_mem[14], ent(1'b0, 0, exp_resp(32'h0055_0042, 0)));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule